// File: doc/BRIEF.md
# Ring-Cascaded FIFO Depth Expander

This block builds one deep first-in first-out buffer out of a ring of identical storage slices. Each slice has its own small memory, its own write and read pointers, and its own occupancy counter. A write strobe and a read strobe are shared by all slices. Ownership of writes and of reads is held as two separate tokens. After reset, one slice holds both tokens. When a slice stores a word in its final location, it hands the write token to its neighbour with a one-cycle pulse. When it reads out its final location, it hands the read token on in the same way. The last slice passes both tokens back to the first.

Words therefore fill the slices in ring order and leave in the same order. Each slice works only with its own narrow pointers, and no pointer ever spans the full capacity. The caller sees a single FIFO of SLICES times DEPTH words. It has an active-high empty flag, which is the AND of every slice's empty flag, and an active-high full flag, which is the AND of every slice's full flag. Read data is registered and held between reads.

Top module: `fifo_chain`

## Requirements
- R1: While reset is low, and after reset is released, `empty` is 1, `full` is 0 and `rd_data` is 0. Both tokens sit in slice 0, the only slice whose first-load strap is tied low.
- R2: A write is accepted when `wr_en` is 1 and `full` is 0. With no reads, `full` rises after exactly SLICES*DEPTH accepted writes.
- R3: At every cycle out of reset, exactly one slice holds the write token and exactly one slice holds the read token.
- R4: A slice passes a token to the next slice in the ring with a one-cycle pulse. It does so when a write, or separately a read, uses its location DEPTH-1. The last slice passes to slice 0. As a result, data crossing slice boundaries and wrapping the ring comes out in write order.
- R5: A read is accepted when `rd_en` is 1 and `empty` is 0. The oldest word appears on `rd_data` right after the clock edge that accepts the read.
- R6: `rd_data` keeps its value in every cycle in which no read is accepted.
- R7: `empty` is 1 exactly when every slice is empty, and `full` is 1 exactly when every slice is full. The two are never 1 together.
- R8: A write strobe while `full` is 1 stores nothing. `full` stays 1 and the next SLICES*DEPTH reads return only the earlier data.
- R9: A read strobe while `empty` is 1 changes nothing. `empty` stays 1 and `rd_data` is unchanged.
- R10: When both strobes are high in one cycle, both transfers take place if the buffer is neither empty nor full. If it is full, only the read is accepted. If it is empty, only the write is accepted.
- R11: The write token and the read token move independently. Any interleaving of strobes over several ring wraps keeps strict FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the reset tree |
| wr_en | input | 1 | Write strobe shared by all slices |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe shared by all slices |
| rd_data | output | WIDTH | Registered word from the latest accepted read |
| empty | output | 1 | High when all slices are empty |
| full | output | 1 | High when all slices are full |

## Verification
The flags come from slice counters that are updated on the edge that accepts a strobe. They are therefore valid for the whole following cycle. The bench compares them with its reference queue just after the falling edge, before it drives the next strobe. `rd_data` passes through one register, so a word is due immediately after the edge that accepts its read. A monitor samples a quarter period after every rising edge. It pops the expected word queued by the driver for that edge. When no read was accepted, it checks that the previous value is still held.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // token handoff pulses travelling along the ring
  typedef struct packed {
    logic wtok;
    logic rtok;
  } chain_tok_t;

  function automatic int ptr_bits(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/chain_ptr.sv
module chain_ptr #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          at_last
);

  logic [AW-1:0] ptr_d;

  assign at_last = (ptr == AW'(DEPTH - 1));

  always_comb begin
    ptr_d = ptr;
    if (step) begin
      if (at_last) ptr_d = '0;
      else         ptr_d = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ptr_d;
  end

endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  chain_tok_t       xi,
  output chain_tok_t       xo,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic             rd_fire,
  output logic [WIDTH-1:0] rd_word,
  output logic             slice_empty,
  output logic             slice_full,
  output logic             wtok_o,
  output logic             rtok_o
);

  localparam int AW = ptr_bits(DEPTH);
  localparam int CW = cnt_bits(DEPTH);

  logic             wtok_q, wtok_d;
  logic             rtok_q, rtok_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [AW-1:0]    wptr, rptr;
  logic             w_last, r_last;
  logic             wr_fire;
  logic [WIDTH-1:0] mem [DEPTH];

  assign slice_empty = (cnt_q == '0);
  assign slice_full  = (cnt_q == CW'(DEPTH));
  assign wr_fire     = wr_en & wtok_q & ~slice_full;
  assign rd_fire     = rd_en & rtok_q & ~slice_empty;
  assign xo.wtok     = wr_fire & w_last;
  assign xo.rtok     = rd_fire & r_last;
  assign wtok_o      = wtok_q;
  assign rtok_o      = rtok_q;
  assign rd_word     = rd_fire ? mem[rptr] : '0;

  chain_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .step(wr_fire), .ptr(wptr), .at_last(w_last)
  );

  chain_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .step(rd_fire), .ptr(rptr), .at_last(r_last)
  );

  // storage: one enabled register row per location
  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_fire && (wptr == AW'(e))) mem[e] <= wr_data;
    end
  end

  always_comb begin
    wtok_d = (wtok_q & ~xo.wtok) | xi.wtok;
    rtok_d = (rtok_q & ~xo.rtok) | xi.rtok;
    unique case ({wr_fire, rd_fire})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok_q <= ~first_load_n;
      rtok_q <= ~first_load_n;
      cnt_q  <= '0;
    end else begin
      wtok_q <= wtok_d;
      rtok_q <= rtok_d;
      if (wr_fire ^ rd_fire) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/chain_merge.sv
module chain_merge #(
  parameter int SLICES = 4,
  parameter int WIDTH  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SLICES-1:0]             rd_fire_vec,
  input  logic [SLICES-1:0][WIDTH-1:0]  word_vec,
  input  logic [SLICES-1:0]             empty_vec,
  input  logic [SLICES-1:0]             full_vec,
  output logic [WIDTH-1:0]              rd_data,
  output logic                          empty,
  output logic                          full
);

  logic [WIDTH-1:0] or_acc [SLICES+1];
  logic [WIDTH-1:0] rd_d;
  logic             any_rd;

  assign or_acc[0] = '0;
  for (genvar s = 0; s < SLICES; s++) begin : g_or
    assign or_acc[s+1] = or_acc[s] | word_vec[s];
  end

  assign any_rd = |rd_fire_vec;
  assign empty  = &empty_vec;
  assign full   = &full_vec;

  always_comb begin
    rd_d = rd_data;
    if (any_rd) rd_d = or_acc[SLICES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (any_rd) rd_data <= rd_d;
  end

endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int SLICES = 4,
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  chain_tok_t                   link [SLICES];
  logic [SLICES-1:0]            rd_fire_vec;
  logic [SLICES-1:0][WIDTH-1:0] word_vec;
  logic [SLICES-1:0]            empty_vec;
  logic [SLICES-1:0]            full_vec;
  logic [SLICES-1:0]            wtok_vec;
  logic [SLICES-1:0]            rtok_vec;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int PREV = (s + SLICES - 1) % SLICES;
    chain_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .first_load_n((s == 0) ? 1'b0 : 1'b1),
      .xi          (link[PREV]),
      .xo          (link[s]),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_fire     (rd_fire_vec[s]),
      .rd_word     (word_vec[s]),
      .slice_empty (empty_vec[s]),
      .slice_full  (full_vec[s]),
      .wtok_o      (wtok_vec[s]),
      .rtok_o      (rtok_vec[s])
    );
  end

  chain_merge #(.SLICES(SLICES), .WIDTH(WIDTH)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire_vec(rd_fire_vec),
    .word_vec   (word_vec),
    .empty_vec  (empty_vec),
    .full_vec   (full_vec),
    .rd_data    (rd_data),
    .empty      (empty),
    .full       (full)
  );

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int SLICES = 4,
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WIDTH-1:0]  rd_data,
  input logic              empty,
  input logic              full,
  input logic [SLICES-1:0] wtok_vec,
  input logic [SLICES-1:0] rtok_vec
);

  localparam int CAP = SLICES * DEPTH;
  localparam int OW  = $clog2(CAP + 1);

  logic [OW-1:0] occ_q;
  logic          acc_w, acc_r;

  assign acc_w = wr_en & ~full;
  assign acc_r = rd_en & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else if (acc_w & ~acc_r) occ_q <= occ_q + 1'b1;
    else if (acc_r & ~acc_w) occ_q <= occ_q - 1'b1;
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R7
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (occ_q == '0)); // R7
  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occ_q == OW'(CAP))); // R2
  AST_WTOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok_vec) == 1); // R3
  AST_RTOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok_vec) == 1); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !empty) |=> $stable(rd_data)); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full); // R8
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty); // R9

endmodule

bind fifo_chain fifo_chain_chk #(.SLICES(SLICES), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .empty   (empty),
  .full    (full),
  .wtok_vec(wtok_vec),
  .rtok_vec(rtok_vec)
);

// File: tb/tb_fifo_chain.sv
module tb_fifo_chain;

  localparam int CLK_PERIOD = 10;
  localparam int SLICES = 4;
  localparam int DEPTH  = 8;
  localparam int W      = 9;
  localparam int CAP    = SLICES * DEPTH;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic         rd_en;
  logic [W-1:0] rd_data;
  logic         empty;
  logic         full;

  logic [W-1:0] model_q [$];
  logic [W-1:0] rd_exp_q [$];
  logic [W-1:0] last_rd;
  logic [15:0]  lfsr;
  int n_chk;
  int n_fail;

  fifo_chain #(.SLICES(SLICES), .DEPTH(DEPTH), .WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of strobes, reference model updated before the edge
  task automatic step(input logic w, input logic r, input logic [W-1:0] d);
    logic aw, ar;
    chk("R7 empty", empty, model_q.size() == 0);
    chk("R7 full", full, model_q.size() == CAP);
    aw = w && (model_q.size() < CAP);
    ar = r && (model_q.size() > 0);
    if (ar) rd_exp_q.push_back(model_q.pop_front());
    if (aw) model_q.push_back(d);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    model_q.delete();
    #1;
    chk("R1 empty in reset", empty, 1'b1);
    chk("R1 full in reset", full, 1'b0);
    chk("R1 rd_data in reset", rd_data, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compare rd_data a quarter period after every rising edge
  initial begin
    last_rd = '0;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (!rst_n) begin
        last_rd = '0;
        rd_exp_q.delete();
      end else if (rd_exp_q.size() > 0) begin
        last_rd = rd_exp_q.pop_front();
        chk("R5 read word", rd_data, last_rd);
      end else begin
        chk("R6 hold", rd_data, last_rd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; lfsr = 16'hACE1;
    do_reset();
    chk("R1 empty after release", empty, 1'b1);
    chk("R1 full after release", full, 1'b0);

    // R9: read on empty changes nothing
    step(1'b0, 1'b1, '0);
    chk("R9 empty stays", empty, 1'b1);

    // short exchange inside slice 0
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, W'(9'h100 + i));
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0);

    // R2/R4: fill across every slice boundary, ring wrap comes from the offset start
    for (int i = 0; i < CAP; i++) begin
      chk("R2 not full yet", full, 1'b0);
      step(1'b1, 1'b0, W'(i * 7 + 3));
    end
    chk("R2 full after capacity", full, 1'b1);
    // R8: write while full is dropped
    step(1'b1, 1'b0, 9'h1FF);
    chk("R8 full stays", full, 1'b1);
    // R10: both strobes while full, only the read happens
    step(1'b1, 1'b1, 9'h155);
    chk("R10 full drops after read", full, 1'b0);
    // R4: drain in order across slices
    for (int i = 0; i < CAP - 1; i++) step(1'b0, 1'b1, '0);
    chk("R7 empty after drain", empty, 1'b1);
    // R10: both strobes while empty, only the write happens
    step(1'b1, 1'b1, 9'h0AA);
    chk("R10 write landed", empty, 1'b0);
    step(1'b0, 1'b1, '0);

    // R10/R11: steady streaming with one word in flight, several ring wraps
    step(1'b1, 1'b0, 9'h011);
    for (int i = 0; i < 3 * CAP; i++) step(1'b1, 1'b1, W'(i ^ 9'h0C3));

    // R11: irregular strobes driven by a shift register
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | (lfsr[5] & lfsr[7]), W'(lfsr[12:4]));
    end
    while (model_q.size() > 0) step(1'b0, 1'b1, '0);
    chk("R11 drained empty", empty, 1'b1);

    // R1: reset with data inside restores the start state
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, W'(i + 40));
    do_reset();
    chk("R1 empty after mid reset", empty, 1'b1);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, W'(i + 200));
    while (model_q.size() > 0) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule